// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This block is the purely combinational hazard logic of an in-order, single-issue, five-stage integer pipeline. It looks at the source register indices of the instruction in the execute stage. It compares them with the destinations of the two older instructions still in flight, which sit in the EX/MEM and MEM/WB pipeline registers. From that comparison it picks, for each of the two ALU operands, where the value comes from: the value read from the register file, the EX/MEM result, or the MEM/WB result.

Only read-after-write dependences need handling. Issue and writeback both happen in program order, so write-after-read and write-after-write orderings are preserved without help. Forwarding cannot cover one case: a load in EX whose destination is needed by the instruction in ID. For that case the unit raises a stall. The stall freezes the PC and the IF/ID register, and a companion control turns the next ID/EX contents into a bubble. After that single bubble, the loaded value reaches the consumer through the MEM/WB path. A dependence three instructions apart is covered by a register file that returns a value written in the same cycle it is read.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Operand select encoding is 0 = register file, 1 = EX/MEM result, 2 = MEM/WB result, and 3 never appears. A source selects 1 when the EX/MEM producer writes, its destination is nonzero, equals the source, and the producer is not a load.
- R2: A source selects 2 when the MEM/WB producer writes to a nonzero destination equal to the source, and the EX/MEM producer does not qualify under R1.
- R3: When both producers qualify for the same source, the EX/MEM (younger) value is selected.
- R4: A producer whose register-write flag is clear never causes forwarding from its stage.
- R5: A destination of register 0 never forwards and never raises a stall.
- R6: The stall and the bubble control are both high exactly when the instruction in EX is a writing load whose nonzero destination equals a used source of the instruction in ID. A non-load in EX never stalls.
- R7: A source whose decode use flag is low never causes a stall.
- R8: A non-load producer followed at once by a dependent instruction costs zero bubbles and delivers the correct value.
- R9: A load followed at once by a dependent instruction costs exactly one bubble. The pair completes one cycle later than a hazard-free pair (3 cycles for 2 instructions in steady state), with the loaded value correct.
- R10: Dependences at distances 2 and 3 cost no bubbles and deliver correct values. Distance 3 relies on a write-through register file.
- R11: An EX/MEM producer that is a load is never selected. The source falls back to MEM/WB or to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | AW | First source index of the instruction in ID |
| id_rs2_i | input | AW | Second source index of the instruction in ID |
| id_use_rs1_i | input | 1 | Decode says ID instruction reads its first source |
| id_use_rs2_i | input | 1 | Decode says ID instruction reads its second source |
| ex_rs1_i | input | AW | First source index of the instruction in EX |
| ex_rs2_i | input | AW | Second source index of the instruction in EX |
| ex_rd_i | input | AW | Destination of the instruction in EX |
| ex_wen_i | input | 1 | Instruction in EX writes a register |
| ex_load_i | input | 1 | Instruction in EX is a load |
| exm_rd_i | input | AW | Destination held in EX/MEM |
| exm_wen_i | input | 1 | EX/MEM producer writes a register |
| exm_load_i | input | 1 | EX/MEM producer is a load |
| mwb_rd_i | input | AW | Destination held in MEM/WB |
| mwb_wen_i | input | 1 | MEM/WB producer writes a register |
| fwd_a_o | output | 2 | Select for the first EX operand |
| fwd_b_o | output | 2 | Select for the second EX operand |
| stall_o | output | 1 | Hold PC and IF/ID this cycle |
| idex_bubble_o | output | 1 | Load a bubble into ID/EX this cycle |

## Verification
Forwarding and stalling often fall in the same cycle. While a load sits in EX and stalls its consumer in ID, the instruction in EX can itself need values from both EX/MEM and MEM/WB. A bench pipeline skeleton provokes this with back-to-back writers, loads and consumers. It judges the outcome by comparing the final register contents with a sequential reference model, and by checking that the total cycle count equals the instruction count plus fill plus the load-use bubbles predicted from R9. Direct vectors cover the priority, x0, unused-operand and load-in-EX/MEM corners.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Widest register index the comparison helpers accept.
  localparam int unsigned IDX_MAX_W = 8;

  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } opnd_src_e;

  // A producer can satisfy a reader when it writes a real register
  // (not x0) and that register is the one being read.
  function automatic logic idx_hit(input logic [IDX_MAX_W-1:0] src,
                                   input logic [IDX_MAX_W-1:0] dst,
                                   input logic                 wen);
    return wen && (dst != '0) && (dst == src);
  endfunction

endpackage

// File: rtl/hzd_src_sel.sv
module hzd_src_sel #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0]        src_idx_i,
  input  logic [AW-1:0]        exm_rd_i,
  input  logic                 exm_wen_i,
  input  logic                 exm_load_i,
  input  logic [AW-1:0]        mwb_rd_i,
  input  logic                 mwb_wen_i,
  output hzd_pkg::opnd_src_e   sel_o,
  output logic                 exm_hit_o,
  output logic                 mwb_hit_o
);
  import hzd_pkg::*;

  localparam int unsigned XW = IDX_MAX_W;

  // A load in EX/MEM only holds an address there, so it cannot feed EX.
  assign exm_hit_o = idx_hit(XW'(src_idx_i), XW'(exm_rd_i), exm_wen_i) && !exm_load_i;
  assign mwb_hit_o = idx_hit(XW'(src_idx_i), XW'(mwb_rd_i), mwb_wen_i);

  always_comb begin
    if (exm_hit_o)      sel_o = SRC_EXMEM;
    else if (mwb_hit_o) sel_o = SRC_MEMWB;
    else                sel_o = SRC_RF;
  end

endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src_idx_i,
  input  logic [NSRC-1:0]         src_use_i,
  input  logic [AW-1:0]           ex_rd_i,
  input  logic                    ex_wen_i,
  input  logic                    ex_load_i,
  output logic [NSRC-1:0]         src_hit_o,
  output logic                    stall_o
);
  import hzd_pkg::*;

  localparam int unsigned XW = IDX_MAX_W;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit_o[s] = src_use_i[s] &&
                          idx_hit(XW'(src_idx_i[s]), XW'(ex_rd_i), ex_wen_i);
  end

  assign stall_o = ex_load_i && (|src_hit_o);

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_use_rs1_i,
  input  logic          id_use_rs2_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wen_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          exm_wen_i,
  input  logic          exm_load_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_wen_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          stall_o,
  output logic          idex_bubble_o
);
  import hzd_pkg::*;

  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0][AW-1:0] ex_src;
  logic [NSRC-1:0][AW-1:0] id_src;
  logic [NSRC-1:0]         id_use;
  opnd_src_e               src_sel  [NSRC];
  logic [NSRC-1:0]         exm_hit;
  logic [NSRC-1:0]         mwb_hit;
  logic [NSRC-1:0]         lu_hit;
  logic                    lu_stall;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};
  assign id_use = {id_use_rs2_i, id_use_rs1_i};

  for (genvar s = 0; s < NSRC; s++) begin : g_byp
    hzd_src_sel #(.AW(AW)) u_sel (
      .src_idx_i (ex_src[s]),
      .exm_rd_i  (exm_rd_i),
      .exm_wen_i (exm_wen_i),
      .exm_load_i(exm_load_i),
      .mwb_rd_i  (mwb_rd_i),
      .mwb_wen_i (mwb_wen_i),
      .sel_o     (src_sel[s]),
      .exm_hit_o (exm_hit[s]),
      .mwb_hit_o (mwb_hit[s])
    );
  end

  hzd_loaduse #(.AW(AW), .NSRC(NSRC)) u_lu (
    .src_idx_i(id_src),
    .src_use_i(id_use),
    .ex_rd_i  (ex_rd_i),
    .ex_wen_i (ex_wen_i),
    .ex_load_i(ex_load_i),
    .src_hit_o(lu_hit),
    .stall_o  (lu_stall)
  );

  assign fwd_a_o       = src_sel[0];
  assign fwd_b_o       = src_sel[1];
  assign stall_o       = lu_stall;
  assign idex_bubble_o = lu_stall;

endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] id_rs1_i,
  input logic [AW-1:0] id_rs2_i,
  input logic          id_use_rs1_i,
  input logic          id_use_rs2_i,
  input logic [AW-1:0] ex_rs1_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_wen_i,
  input logic          ex_load_i,
  input logic [AW-1:0] exm_rd_i,
  input logic          exm_wen_i,
  input logic          exm_load_i,
  input logic [AW-1:0] mwb_rd_i,
  input logic          mwb_wen_i,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          stall_o,
  input logic          idex_bubble_o
);
  logic known;
  logic both_match_a;

  assign known = !$isunknown({id_rs1_i, id_rs2_i, id_use_rs1_i, id_use_rs2_i,
                              ex_rs1_i, ex_rd_i, ex_wen_i, ex_load_i,
                              exm_rd_i, exm_wen_i, exm_load_i, mwb_rd_i,
                              mwb_wen_i, fwd_a_o, fwd_b_o, stall_o,
                              idex_bubble_o});
  assign both_match_a = exm_wen_i && !exm_load_i && (exm_rd_i == ex_rs1_i) &&
                        (ex_rs1_i != '0);

  always_comb begin
    if (known) begin
      a_r1_legal_sel: assert (fwd_a_o != 2'd3 && fwd_b_o != 2'd3)
        else $error("select code 3 seen");
      a_r3_younger_wins: assert (!both_match_a || fwd_a_o == 2'd1)
        else $error("EX/MEM match not preferred");
      a_r4_exm_needs_wen: assert (fwd_a_o != 2'd1 || exm_wen_i)
        else $error("EX/MEM forward without write flag");
      a_r4_mwb_needs_wen: assert (fwd_a_o != 2'd2 || mwb_wen_i)
        else $error("MEM/WB forward without write flag");
      a_r5_x0_no_fwd: assert (ex_rs1_i != '0 || fwd_a_o == 2'd0)
        else $error("x0 operand forwarded");
      a_r5_x0_no_stall: assert (ex_rd_i != '0 || !stall_o)
        else $error("stall on x0 destination");
      a_r6_stall_needs_load: assert (!stall_o || (ex_load_i && ex_wen_i))
        else $error("stall without writing load in EX");
      a_r6_bubble_tracks_stall: assert (stall_o == idex_bubble_o)
        else $error("stall and bubble disagree");
      a_r7_unused_no_stall: assert (id_use_rs1_i || id_use_rs2_i || !stall_o)
        else $error("stall with no used source");
      a_r11_load_not_from_exm: assert (!exm_load_i || fwd_a_o != 2'd1)
        else $error("load address forwarded from EX/MEM");
    end
  end

endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.AW(AW)) u_chk (.*);

// File: tb/fwd_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_hazard_unit_tb_top;

  localparam int AW = 5;

  typedef struct packed {
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       u1;
    logic       u2;
    logic       wen;
    logic       ld;
    logic [7:0] imm;
  } ins_t;

  typedef struct {
    int    ea;
    int    eb;
    int    es;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // DUT pins
  logic [AW-1:0] d_id_rs1, d_id_rs2, d_ex_rs1, d_ex_rs2, d_ex_rd, d_exm_rd, d_mwb_rd;
  logic d_use1, d_use2, d_ex_wen, d_ex_ld, d_exm_wen, d_exm_ld, d_mwb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble;

  // Direct-vector sources
  logic [AW-1:0] v_id_rs1, v_id_rs2, v_ex_rs1, v_ex_rs2, v_ex_rd, v_exm_rd, v_mwb_rd;
  logic v_use1, v_use2, v_ex_wen, v_ex_ld, v_exm_wen, v_exm_ld, v_mwb_wen;

  // Pipeline skeleton
  bit         skel_on = 0;
  bit         sk_rst  = 0;
  ins_t       prog [16];
  int         prog_n = 0;
  int         pc;
  logic       fd_v, ie_v, em_v, mw_v;
  ins_t       fd_i, ie_i, em_i, mw_i;
  logic [31:0] ie_a, ie_b, em_res, mw_val;
  logic [31:0] rf [32];
  logic [31:0] ref_rf [32];
  int         edges, retired, done_edge;
  logic [31:0] rda, rdb, opa, opb, ex_res;

  exp_t sbq [$];

  fwd_hazard_unit #(.AW(AW)) dut_i (
    .id_rs1_i(d_id_rs1), .id_rs2_i(d_id_rs2),
    .id_use_rs1_i(d_use1), .id_use_rs2_i(d_use2),
    .ex_rs1_i(d_ex_rs1), .ex_rs2_i(d_ex_rs2),
    .ex_rd_i(d_ex_rd), .ex_wen_i(d_ex_wen), .ex_load_i(d_ex_ld),
    .exm_rd_i(d_exm_rd), .exm_wen_i(d_exm_wen), .exm_load_i(d_exm_ld),
    .mwb_rd_i(d_mwb_rd), .mwb_wen_i(d_mwb_wen),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .idex_bubble_o(bubble)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a * 32'd3 + 32'd7;
  endfunction

  always_comb begin
    if (skel_on) begin
      d_id_rs1 = fd_i.rs1; d_id_rs2 = fd_i.rs2;
      d_use1 = fd_v && fd_i.u1; d_use2 = fd_v && fd_i.u2;
      d_ex_rs1 = ie_i.rs1; d_ex_rs2 = ie_i.rs2; d_ex_rd = ie_i.rd;
      d_ex_wen = ie_v && ie_i.wen; d_ex_ld = ie_v && ie_i.ld;
      d_exm_rd = em_i.rd; d_exm_wen = em_v && em_i.wen; d_exm_ld = em_v && em_i.ld;
      d_mwb_rd = mw_i.rd; d_mwb_wen = mw_v && mw_i.wen;
    end else begin
      d_id_rs1 = v_id_rs1; d_id_rs2 = v_id_rs2; d_use1 = v_use1; d_use2 = v_use2;
      d_ex_rs1 = v_ex_rs1; d_ex_rs2 = v_ex_rs2; d_ex_rd = v_ex_rd;
      d_ex_wen = v_ex_wen; d_ex_ld = v_ex_ld;
      d_exm_rd = v_exm_rd; d_exm_wen = v_exm_wen; d_exm_ld = v_exm_ld;
      d_mwb_rd = v_mwb_rd; d_mwb_wen = v_mwb_wen;
    end
  end

  // Register file read with same-cycle write-through from writeback.
  always_comb begin
    rda = (fd_i.rs1 == 5'd0) ? 32'd0 :
          (mw_v && mw_i.wen && mw_i.rd == fd_i.rs1) ? mw_val : rf[fd_i.rs1];
    rdb = (fd_i.rs2 == 5'd0) ? 32'd0 :
          (mw_v && mw_i.wen && mw_i.rd == fd_i.rs2) ? mw_val : rf[fd_i.rs2];
    opa = (fwd_a == 2'd1) ? em_res : (fwd_a == 2'd2) ? mw_val : ie_a;
    opb = (fwd_b == 2'd1) ? em_res : (fwd_b == 2'd2) ? mw_val : ie_b;
    ex_res = ie_i.ld ? opa + 32'(ie_i.imm)
                     : opa + (ie_i.u2 ? opb : 32'd0) + 32'(ie_i.imm);
  end

  always @(posedge clk) begin
    if (sk_rst) begin
      pc <= 0; fd_v <= 0; ie_v <= 0; em_v <= 0; mw_v <= 0;
      fd_i <= '0; ie_i <= '0; em_i <= '0; mw_i <= '0;
      ie_a <= 0; ie_b <= 0; em_res <= 0; mw_val <= 0;
      edges <= 0; retired <= 0; done_edge <= -1;
      for (int i = 0; i < 32; i++) rf[i] <= 32'(i * 5);
    end else if (skel_on) begin
      edges <= edges + 1;
      if (mw_v && mw_i.wen && mw_i.rd != 5'd0) rf[mw_i.rd] <= mw_val;
      mw_v <= em_v; mw_i <= em_i;
      mw_val <= em_i.ld ? memf(em_res) : em_res;
      if (em_v) begin
        retired <= retired + 1;
        if (retired + 1 == prog_n) done_edge <= edges + 1;
      end
      em_v <= ie_v; em_i <= ie_i; em_res <= ex_res;
      if (stall) begin
        ie_v <= 1'b0; ie_i <= '0;
      end else begin
        ie_v <= fd_v; ie_i <= fd_i; ie_a <= rda; ie_b <= rdb;
        fd_v <= (pc < prog_n);
        fd_i <= (pc < prog_n) ? prog[pc[3:0]] : '0;
        if (pc < prog_n) pc <= pc + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor for direct vectors.
  always @(posedge clk) begin
    if (!skel_on && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(fwd_a == 2'(e.ea), {e.tag, " fwd_a"}, fwd_a, e.ea);
      chk(fwd_b == 2'(e.eb), {e.tag, " fwd_b"}, fwd_b, e.eb);
      chk(stall == 1'(e.es) && bubble == 1'(e.es), {e.tag, " stall/bubble"},
          {stall, bubble}, {e.es[0], e.es[0]});
    end
  end

  task automatic vec(input int irs1, input int irs2, input bit u1, input bit u2,
                     input int xrs1, input int xrs2,
                     input int xrd, input bit xw, input bit xl,
                     input int mrd, input bit mw, input bit ml,
                     input int wrd, input bit ww,
                     input int ea, input int eb, input int es, input string tag);
    exp_t e;
    @(negedge clk);
    v_id_rs1 = AW'(irs1); v_id_rs2 = AW'(irs2); v_use1 = u1; v_use2 = u2;
    v_ex_rs1 = AW'(xrs1); v_ex_rs2 = AW'(xrs2);
    v_ex_rd = AW'(xrd); v_ex_wen = xw; v_ex_ld = xl;
    v_exm_rd = AW'(mrd); v_exm_wen = mw; v_exm_ld = ml;
    v_mwb_rd = AW'(wrd); v_mwb_wen = ww;
    e.ea = ea; e.eb = eb; e.es = es; e.tag = tag;
    sbq.push_back(e);
  endtask

  function automatic ins_t mk(input int rd, input int rs1, input int rs2,
                              input bit u1, input bit u2, input bit ld, input int imm);
    ins_t x;
    x.rd = 5'(rd); x.rs1 = 5'(rs1); x.rs2 = 5'(rs2);
    x.u1 = u1; x.u2 = u2; x.wen = 1'b1; x.ld = ld; x.imm = 8'(imm);
    return x;
  endfunction

  task automatic run_prog(input string tag);
    int bub;
    logic [31:0] a, r;
    for (int i = 0; i < 32; i++) ref_rf[i] = 32'(i * 5);
    bub = 0;
    for (int i = 0; i < prog_n; i++) begin
      a = ref_rf[prog[i].rs1];
      r = prog[i].ld ? memf(a + 32'(prog[i].imm))
                     : a + (prog[i].u2 ? ref_rf[prog[i].rs2] : 32'd0) + 32'(prog[i].imm);
      if (prog[i].wen && prog[i].rd != 5'd0) ref_rf[prog[i].rd] = r;
      if (i + 1 < prog_n && prog[i].ld && prog[i].wen && prog[i].rd != 5'd0 &&
          ((prog[i+1].u1 && prog[i+1].rs1 == prog[i].rd) ||
           (prog[i+1].u2 && prog[i+1].rs2 == prog[i].rd)))
        bub++;
    end
    @(negedge clk); sk_rst = 1;
    @(negedge clk); sk_rst = 0; skel_on = 1;
    for (int k = 0; k < 200 && done_edge < 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_edge == prog_n + 3 + bub, {tag, " cycles"}, done_edge, prog_n + 3 + bub);
    begin
      int mism;
      mism = 0;
      for (int i = 0; i < 32; i++) if (rf[i] !== ref_rf[i]) mism++;
      chk(mism == 0, {tag, " register contents"}, mism, 0);
    end
    skel_on = 0;
  endtask

  initial begin
    // idle: no producers -> register file selects, no stall
    vec(0,0,0,0, 0,0, 0,0,0, 0,0,0, 0,0, 0,0,0, "R1 idle");
    vec(0,0,0,0, 3,8, 0,0,0, 3,1,0, 0,0, 1,0,0, "R1 EX/MEM hit");
    vec(0,0,0,0, 2,4, 0,0,0, 0,0,0, 4,1, 0,2,0, "R2 MEM/WB hit");
    vec(0,0,0,0, 7,7, 0,0,0, 7,1,0, 7,1, 1,1,0, "R3 both match");
    vec(0,0,0,0, 6,6, 0,0,0, 6,0,0, 6,1, 2,2,0, "R4 EX/MEM no write");
    vec(0,0,0,0, 6,6, 0,0,0, 9,1,0, 6,0, 0,0,0, "R4 MEM/WB no write");
    vec(0,0,1,1, 0,0, 0,1,1, 0,1,0, 0,1, 0,0,0, "R5 x0");
    vec(3,9,1,1, 0,0, 9,1,1, 0,0,0, 0,0, 0,0,1, "R6 load-use rs2");
    vec(9,3,1,0, 0,0, 9,1,1, 0,0,0, 0,0, 0,0,1, "R6 load-use rs1");
    vec(3,9,1,0, 0,0, 9,1,1, 0,0,0, 0,0, 0,0,0, "R7 unused rs2");
    vec(3,4,1,1, 0,0, 9,1,1, 0,0,0, 0,0, 0,0,0, "R6 load no match");
    vec(9,9,1,1, 0,0, 9,1,0, 0,0,0, 0,0, 0,0,0, "R6 non-load in EX");
    vec(9,9,1,1, 0,0, 9,0,1, 0,0,0, 0,0, 0,0,0, "R4 load without write");
    vec(0,0,0,0, 6,5, 0,0,0, 6,1,1, 6,1, 2,0,0, "R11 load in EX/MEM");
    vec(0,0,0,0, 6,5, 0,0,0, 6,1,1, 3,1, 0,0,0, "R11 load fallback RF");
    @(negedge clk);
    @(negedge clk);

    // R8 / R10: distances 1, 2, 3 with ALU producers
    prog[0] = mk(5, 0, 0, 1, 0, 0, 10);
    prog[1] = mk(6, 5, 5, 1, 1, 0, 0);
    prog[2] = mk(7, 5, 6, 1, 1, 0, 1);
    prog[3] = mk(8, 5, 1, 1, 1, 0, 2);
    prog[4] = mk(9, 6, 7, 1, 1, 0, 3);
    prog_n = 5;
    run_prog("R8 R10 alu chain");

    // R9: load then use
    prog[0] = mk(5, 2, 0, 1, 0, 1, 4);
    prog[1] = mk(6, 5, 7, 1, 1, 0, 0);
    prog_n = 2;
    run_prog("R9 load-use pair");

    // R3 priority, R5 x0 load, R7 unused operand, R10 load at distance 2
    prog[0] = mk(5, 1, 0, 1, 0, 0, 1);
    prog[1] = mk(5, 2, 0, 1, 0, 0, 3);
    prog[2] = mk(6, 5, 5, 1, 1, 0, 0);
    prog[3] = mk(0, 3, 0, 1, 0, 1, 0);
    prog[4] = mk(7, 0, 0, 1, 1, 0, 2);
    prog[5] = mk(8, 4, 0, 1, 0, 1, 0);
    prog[6] = mk(9, 10, 8, 1, 0, 0, 1);
    prog[7] = mk(11, 8, 9, 1, 1, 0, 0);
    prog_n = 8;
    run_prog("R3 R5 R7 mixed");

    // R9: load-use on second source and chained load-use
    prog[0] = mk(12, 1, 0, 1, 0, 1, 2);
    prog[1] = mk(13, 1, 12, 1, 1, 0, 0);
    prog[2] = mk(14, 13, 0, 1, 0, 1, 0);
    prog[3] = mk(15, 14, 0, 1, 0, 0, 5);
    prog_n = 4;
    run_prog("R9 chained loads");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule